// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is an 8-bit control register that software writes over a simple bus. It drives the power-state sequencing of a small microcontroller. Writes to the register can ask for a mode. Stop, sleep and timebase-timer each have a request bit, and an internal reset has one too. The stop and sleep bits act when written 1. The timebase-timer and reset bits act when written 0. These trigger bits are write-only. The register also keeps a pin-policy bit and a 2-bit pause setting, which software can read back.

A requested mode appears as a level on its output and stays there until the wake input clears it. The pin policy decides whether the pins float or hold their levels while stop or timebase-timer mode is active. The pause setting controls intermittent CPU operation. After each CPU access strobe, the CPU clock enable is held low for 0, 8, 16 or 32 resource-clock cycles.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, a read returns 8'h18. All mode outputs and `int_rst` are low, `pin_hiz` is low and `cpu_clk_en` is high.
- R2: The read layout is fixed:
  - bits 7, 6 and 0 read 0.
  - bits 4 and 3 read 1.
  - bit 5 returns the stored pin-policy bit.
  - bits 2:1 return the stored pause code.
  - A value written to bit 0 is discarded.
- R3: A write with bit 7 = 1 (and bit 4 = 1) raises `stop_req` in the cycle after the write.
- R4: A write with bit 6 = 1 (and bit 4 = 1, bit 7 = 0, bit 3 = 1) raises `sleep_req` in the cycle after the write.
- R5: A write with bit 3 = 0 (and bit 4 = 1, bit 7 = 0) raises `tbt_req` in the cycle after the write.
- R6: When one write requests several modes, the order of precedence is stop, then timebase-timer, then sleep. At most one mode output is high at any time.
- R7: A write with bit 4 = 0 drives `int_rst` high for exactly 3 cycles, starting in the cycle after the write. That write clears any active mode and starts no new one.
- R8: A mode output stays high until `wake_irq` is sampled high, and is low from the next cycle.
  - `wake_irq` takes precedence over a mode request written in the same cycle.
  - A write that requests nothing leaves the current mode unchanged.
- R9: `pin_hiz` equals the stored bit 5 while `stop_req` or `tbt_req` is high. It is low otherwise, including during sleep.
- R10: With a pause code of 00, 01, 10 or 11 in bits 2:1, a `cpu_strobe` drives `cpu_clk_en` low for 0, 8, 16 or 32 cycles respectively, starting in the next cycle. A strobe that arrives while a pause is running is ignored.
- R11: A write happens only when `bus_sel` and `bus_we` are both high. Otherwise the register, the modes and `int_rst` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resource clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| wake_irq | input | 1 | Interrupt wake-up, clears the active mode |
| cpu_strobe | input | 1 | CPU access strobe that starts a pause |
| stop_req | output | 1 | Stop mode request level |
| sleep_req | output | 1 | Sleep mode request level |
| tbt_req | output | 1 | Timebase-timer mode request level |
| int_rst | output | 1 | Internal reset pulse |
| pin_hiz | output | 1 | Pin high-impedance enable |
| cpu_clk_en | output | 1 | CPU clock enable (low while paused) |

## Verification
Every write takes effect on the clock edge that samples it, and a strobe or wake input likewise acts on the edge that samples it:
- The mode levels, the read data and `pin_hiz` change one cycle after that edge.
- `int_rst` rises in that cycle and stays high for three cycles.
- `cpu_clk_en` falls in that cycle and stays low for the selected count.

The bench drives inputs on falling edges and samples on the next falling edge, so each result is read in the first cycle it is due. It also counts the high or low cycles of a pulse one falling edge at a time. All 256 write values are swept from an idle mode, and the expected mode, read data, pin enable and reset length are computed from the bit rules.

// File: rtl/lpm_pkg.sv
// Shared types and bit positions for the low-power mode control register.
package lpm_pkg;
    localparam int REG_W     = 8;
    localparam int BIT_STOP  = 7;
    localparam int BIT_SLEEP = 6;
    localparam int BIT_PIN   = 5;
    localparam int BIT_RST   = 4;
    localparam int BIT_TBT   = 3;
    localparam int BIT_PH    = 2;
    localparam int BIT_PL    = 1;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_TBT   = 2'd2,
        MODE_STOP  = 2'd3
    } lpm_mode_e;
endpackage

// File: rtl/lpm_cfg_reg.sv
// Register file: keeps the pin-policy bit and the pause code, decodes the
// write-only trigger bits of a write into single-cycle request strobes,
// and forms the read data.
// Assumes: one write per cycle, qualified by wr_en; trigger outputs are
// combinational and only valid in the write cycle.
module lpm_cfg_reg
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             pin_sel,
    output logic [1:0]       pause_code,
    output logic             req_stop,
    output logic             req_sleep,
    output logic             req_tbt,
    output logic             req_rst
);
    // Store the readable fields on every qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sel    <= 1'b0;
            pause_code <= 2'b00;
        end else if (wr_en) begin
            pin_sel    <= wdata[BIT_PIN];
            pause_code <= wdata[BIT_PH:BIT_PL];
        end
    end

    // Decode trigger bits: stop/sleep act on 1, timebase/reset act on 0.
    always_comb begin
        req_stop  = wr_en &  wdata[BIT_STOP];
        req_sleep = wr_en &  wdata[BIT_SLEEP];
        req_tbt   = wr_en & ~wdata[BIT_TBT];
        req_rst   = wr_en & ~wdata[BIT_RST];
    end

    // Read data: write-only bits return their reset level, bit 0 reads 0.
    assign rdata = {1'b0, 1'b0, pin_sel, 1'b1, 1'b1, pause_code, 1'b0};

    // R11: without a write the readable fields never move.
    p_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rdata));
endmodule

// File: rtl/lpm_mode_seq.sv
// Mode sequencer: holds the active low-power mode. Precedence is
// reset > wake > stop > timebase > sleep > hold.
// Assumes: request strobes are single-cycle and already qualified by a write.
module lpm_mode_seq
    import lpm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_stop,
    input  logic req_sleep,
    input  logic req_tbt,
    input  logic req_rst,
    input  logic wake,
    output logic stop_o,
    output logic sleep_o,
    output logic tbt_o
);
    lpm_mode_e mode_q, mode_d;

    // Next-mode selection by fixed precedence.
    always_comb begin
        mode_d = mode_q;
        if (req_rst)        mode_d = MODE_RUN;
        else if (wake)      mode_d = MODE_RUN;
        else if (req_stop)  mode_d = MODE_STOP;
        else if (req_tbt)   mode_d = MODE_TBT;
        else if (req_sleep) mode_d = MODE_SLEEP;
    end

    // Mode state register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // Level outputs decoded from the state.
    assign stop_o  = (mode_q == MODE_STOP);
    assign sleep_o = (mode_q == MODE_SLEEP);
    assign tbt_o   = (mode_q == MODE_TBT);

    // R6: stop outranks every other request in the same write.
    p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stop && !req_rst && !wake) |=> stop_o);
    // R8: wake clears the mode in the following cycle.
    p_wake_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !(stop_o || sleep_o || tbt_o));
    // R7: a reset write leaves no mode active.
    p_rst_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_rst |=> !(stop_o || sleep_o || tbt_o));
endmodule

// File: rtl/lpm_rst_pulse.sv
// Internal reset pulse generator: a trigger starts (or restarts) a pulse
// PULSE_LEN cycles long, beginning in the cycle after the trigger.
// Assumes: PULSE_LEN >= 3 (the length check below uses a fixed depth).
module lpm_rst_pulse #(
    parameter int PULSE_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_o
);
    localparam int CW = $clog2(PULSE_LEN + 1);
    logic [CW-1:0] cnt_q;

    // Down-counter loaded by the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (trig)         cnt_q <= CW'(PULSE_LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_o = (cnt_q != '0);

    // R7: pulse starts in the cycle after the trigger.
    p_rst_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse_o);
    // R7: a falling pulse was high for at least three cycles.
    p_rst_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_o) |-> ($past(pulse_o, 2) && $past(pulse_o, 3)));
endmodule

// File: rtl/lpm_pause_gen.sv
// Pause generator: after a CPU access strobe, holds the CPU clock enable
// low for 0, BASE, 2*BASE or 4*BASE cycles selected by a 2-bit code.
// Assumes: strobes seen during a running pause belong to the stalled CPU
// and are ignored.
module lpm_pause_gen #(
    parameter int BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code,
    input  logic       strobe,
    output logic       clk_en
);
    localparam int MAXC = BASE * 4;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] load_v;

    // Pause length for the current code.
    always_comb begin
        case (code)
            2'b01:   load_v = CW'(BASE);
            2'b10:   load_v = CW'(BASE * 2);
            2'b11:   load_v = CW'(BASE * 4);
            default: load_v = '0;
        endcase
    end

    // Pause counter: loads on an idle strobe, counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (strobe && cnt_q == '0)  cnt_q <= load_v;
        else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
    end

    assign clk_en = (cnt_q == '0);

    // R10: an idle strobe with a nonzero code gates the clock next cycle.
    p_pause_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && clk_en && code != 2'b00) |=> !clk_en);
    // R10: with code 00 an idle strobe never gates the clock.
    p_pause_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && clk_en && code == 2'b00) |=> clk_en);
endmodule

// File: rtl/lpm_ctrl.sv
// Top of the low-power mode control register: bus write qualification,
// register file, mode sequencer, reset pulse and pause generator.
// Assumes: the bus reads bus_rdata combinationally; wake_irq and
// cpu_strobe are synchronous to clk.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int RST_PULSE  = 3,
    parameter int PAUSE_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             wake_irq,
    input  logic             cpu_strobe,
    output logic             stop_req,
    output logic             sleep_req,
    output logic             tbt_req,
    output logic             int_rst,
    output logic             pin_hiz,
    output logic             cpu_clk_en
);
    logic       wr_en;
    logic       pin_sel;
    logic [1:0] pause_code;
    logic       req_stop, req_sleep, req_tbt, req_rst;

    // Qualify a bus write.
    assign wr_en = bus_sel & bus_we;

    lpm_cfg_reg u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .pin_sel    (pin_sel),
        .pause_code (pause_code),
        .req_stop   (req_stop),
        .req_sleep  (req_sleep),
        .req_tbt    (req_tbt),
        .req_rst    (req_rst)
    );

    lpm_mode_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_stop  (req_stop),
        .req_sleep (req_sleep),
        .req_tbt   (req_tbt),
        .req_rst   (req_rst),
        .wake      (wake_irq),
        .stop_o    (stop_req),
        .sleep_o   (sleep_req),
        .tbt_o     (tbt_req)
    );

    lpm_rst_pulse #(.PULSE_LEN(RST_PULSE)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (req_rst),
        .pulse_o (int_rst)
    );

    lpm_pause_gen #(.BASE(PAUSE_BASE)) u_pause (
        .clk    (clk),
        .rst_n  (rst_n),
        .code   (pause_code),
        .strobe (cpu_strobe),
        .clk_en (cpu_clk_en)
    );

    // Pin policy applies only in stop and timebase-timer modes.
    assign pin_hiz = pin_sel & (stop_req | tbt_req);

    // R9: pins never float outside stop or timebase-timer mode.
    p_hiz_modes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_hiz |-> (stop_req || tbt_req));
    // R6: at most one mode level is high.
    p_one_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_req, sleep_req, tbt_req}));
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wake_irq = 1'b0, cpu_strobe = 1'b0;
    logic       stop_req, sleep_req, tbt_req, int_rst, pin_hiz, cpu_clk_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_irq(wake_irq),
        .cpu_strobe(cpu_strobe), .stop_req(stop_req), .sleep_req(sleep_req),
        .tbt_req(tbt_req), .int_rst(int_rst), .pin_hiz(pin_hiz),
        .cpu_clk_en(cpu_clk_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Write one value; returns at the falling edge after the write edge.
    task automatic wr(input logic [7:0] v);
        @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = v;
        @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wake();
        @(negedge clk); wake_irq = 1'b1;
        @(negedge clk); wake_irq = 1'b0;
    endtask

    function automatic logic [2:0] exp_mode(input logic [7:0] v);
        // {stop, tbt, sleep}
        if (!v[4])      return 3'b000;
        else if (v[7])  return 3'b100;
        else if (!v[3]) return 3'b010;
        else if (v[6])  return 3'b001;
        else            return 3'b000;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] v);
        return {2'b00, v[5], 2'b11, v[2:1], 1'b0};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 8'h18);
        chk("R1 modes", {stop_req, tbt_req, sleep_req}, 3'b000);
        chk("R1 int_rst", int_rst, 1'b0);
        chk("R1 pin_hiz", pin_hiz, 1'b0);
        chk("R1 cpu_clk_en", cpu_clk_en, 1'b1);

        // Exhaustive write sweep: R2..R7, R9
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v;
            logic [2:0] m;
            int hi;
            v = 8'(i);
            wake();
            wr(v);
            m = exp_mode(v);
            chk("R3/R4/R5/R6 mode", {stop_req, tbt_req, sleep_req}, m);
            chk("R2 rdata", bus_rdata, exp_rd(v));
            chk("R9 pin_hiz", pin_hiz, v[5] & (m[2] | m[1]));
            hi = 0;
            for (int k = 0; k < 5; k++) begin
                if (int_rst) hi++;
                @(negedge clk);
            end
            chk("R7 int_rst length", hi, v[4] ? 0 : 3);
        end

        // R7: a reset write clears an active mode
        wake();
        wr(8'h98);
        chk("R3 stop set", stop_req, 1'b1);
        wr(8'h88);
        chk("R7 reset clears stop", {stop_req, tbt_req, sleep_req}, 3'b000);
        chk("R7 pulse high", int_rst, 1'b1);
        repeat (4) @(negedge clk);

        // R8: mode holds, idle write keeps it, wake clears it
        wr(8'h58);
        repeat (10) @(negedge clk);
        chk("R8 sleep held", sleep_req, 1'b1);
        wr(8'h18);
        chk("R8 idle write keeps sleep", sleep_req, 1'b1);
        chk("R9 no hiz in sleep", pin_hiz, 1'b0);
        wake();
        chk("R8 wake clears", {stop_req, tbt_req, sleep_req}, 3'b000);
        // R8: wake beats a simultaneous request
        @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'hB8; wake_irq = 1'b1;
        @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0; wake_irq = 1'b0;
        chk("R8 wake wins", {stop_req, tbt_req, sleep_req}, 3'b000);
        // R8: new request replaces an active one
        wr(8'h58);
        wr(8'h10);
        chk("R8 replace by tbt", {stop_req, tbt_req, sleep_req}, 3'b010);
        wake();

        // R11: no write without both select and write enable
        wr(8'h3E);
        @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_wdata = 8'h80;
        @(negedge clk); bus_sel = 1'b0; bus_we = 1'b1; bus_wdata = 8'h00;
        @(negedge clk); bus_we = 1'b0;
        chk("R11 rdata kept", bus_rdata, 8'h3E);
        chk("R11 no mode", {stop_req, tbt_req, sleep_req}, 3'b000);
        chk("R11 no reset", int_rst, 1'b0);

        // R10: pause lengths for every code
        for (int c = 0; c < 4; c++) begin
            int lows;
            int expl;
            wr(8'h18 | 8'(c << 1));
            expl = (c == 0) ? 0 : (4 << c);
            @(negedge clk); cpu_strobe = 1'b1;
            @(negedge clk); cpu_strobe = 1'b0;
            lows = 0;
            for (int k = 0; k < 40; k++) begin
                if (!cpu_clk_en) lows++;
                if (c == 1 && k == 3) cpu_strobe = 1'b1;
                @(negedge clk);
                cpu_strobe = 1'b0;
            end
            chk("R10 pause cycles", lows, expl);
            chk("R10 enable restored", cpu_clk_en, 1'b1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule